// File: doc/BRIEF.md
# Programmable Time-Slot Assigner

This block maps two 8-bit bearer channels (B1, B2) and one 2-bit signalling channel (D) onto a serial TDM bus. The bus has one transmit line and one receive line, and a frame holds up to 512 bits. Each clock cycle of `clk_i` is one bit time. A frame sync pulse restarts the bit counter. Comparators then pick out the bits that belong to each channel.

Each direction has its own slot number for B1 and for B2. The D channel uses a 2-bit slot chosen from 256 positions. The D channel can instead be taken off the bus and sent to a separate port. On transmit, the block drives the line and raises an output enable only inside granted slots. On receive, it shifts the granted bits into one byte per channel and presents that byte with a one-cycle valid pulse. All configuration inputs are copied into shadow registers at frame sync.

Top module: `tdm_slot_assigner`

## Requirements
- R1: After reset, and until the first frame sync, `ser_tx_oe_o`, every receive valid and `dport_on_o` are 0.
- R2: When `fsync_i` is high at a clock edge, the next cycle is bit 0 of the frame. Each later cycle is the next bit. B slot s covers bits 8s..8s+7, and D slot d covers bits 2d and 2d+1.
- R3: During a granted transmit bit, `ser_tx_oe_o` is 1 and `ser_tx_o` carries the channel data MSB first. Bit offset k of a B slot sends data bit 7-k. D sends bit 1 first, then bit 0.
- R4: `ser_tx_oe_o` is 0 on every bit that is not granted to a transmit channel, so the line is high impedance there.
- R5: Transmit and receive slot numbers are independent; a channel may sit at different slots in each direction.
- R6: Receive bytes are assembled MSB first from the granted bits of `ser_rx_i`. The valid output is high for exactly one cycle, the cycle after the slot's last bit, and the data is valid with it.
- R7: The number of active B slots is `frame_slots_i`, with values above 64 treated as 64. Bits at or beyond 8 times that count never grant any channel. Slot numbers at or beyond the count are never active, and a count of 0 grants nothing.
- R8: With the D port enabled, the D slot is not used on the bus in either direction: there is no output enable and no D receive valid. `dport_on_o` is 1 in that case.
- R9: Overlapping assignments in one direction resolve with B1 over B2 and B2 over D. A channel that loses gets neither bus drive nor a valid pulse.
- R10: Configuration inputs are sampled only at frame sync. Changes made inside a frame act from the next frame.
- R11: Once the count passes the frame limit, no channel is granted again until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync, high for the cycle before bit 0 |
| frame_slots_i | input | 7 | Active 8-bit slots per frame |
| dport_en_i | input | 1 | 1 moves D off the bus to its own port |
| tx_b1_slot_i | input | 6 | Transmit B1 slot |
| tx_b2_slot_i | input | 6 | Transmit B2 slot |
| tx_d_slot_i | input | 8 | Transmit D 2-bit slot |
| rx_b1_slot_i | input | 6 | Receive B1 slot |
| rx_b2_slot_i | input | 6 | Receive B2 slot |
| rx_d_slot_i | input | 8 | Receive D 2-bit slot |
| b1_tx_data_i | input | 8 | B1 transmit byte |
| b2_tx_data_i | input | 8 | B2 transmit byte |
| d_tx_data_i | input | 2 | D transmit bits |
| ser_tx_o | output | 1 | Serial transmit data |
| ser_tx_oe_o | output | 1 | Transmit line output enable |
| ser_rx_i | input | 1 | Serial receive data |
| b1_rx_data_o | output | 8 | B1 received byte |
| b1_rx_vld_o | output | 1 | B1 receive valid pulse |
| b2_rx_data_o | output | 8 | B2 received byte |
| b2_rx_vld_o | output | 1 | B2 receive valid pulse |
| d_rx_data_o | output | 2 | D received bits |
| d_rx_vld_o | output | 1 | D receive valid pulse |
| dport_on_o | output | 1 | Sampled D port enable for this frame |

## Verification
The assertions assume that `fsync_i` is a clean synchronous pulse and that the serial data is sampled once per bit. They also assume that the transmit data inputs are held steady by their source for the whole slot. The bench drives every input on the falling edge and holds transmit bytes constant within a slot. The receive bits come from an LFSR that changes only on the falling edge. Configuration changes inside a frame happen only in the phase that targets R10. Frame lengths there stay small enough to sweep each slot position and the out-of-range slots.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int MAX_SLOTS = 64;
  localparam int SLOT_BITS = 8;
  localparam int D_BITS    = 2;
  localparam int B_SLOT_W  = $clog2(MAX_SLOTS);
  localparam int D_SLOT_W  = $clog2(MAX_SLOTS * SLOT_BITS / D_BITS);
  localparam int FSLOT_W   = B_SLOT_W + 1;
  localparam int POS_W     = $clog2(MAX_SLOTS * SLOT_BITS);
  localparam int CNT_W     = POS_W + 1;

  typedef struct packed {
    logic [B_SLOT_W-1:0] b1;
    logic [B_SLOT_W-1:0] b2;
    logic [D_SLOT_W-1:0] d;
  } dir_cfg_t;

  typedef struct packed {
    dir_cfg_t            tx;
    dir_cfg_t            rx;
    logic [FSLOT_W-1:0]  frame_slots;
    logic                dport_en;
  } tsa_cfg_t;
endpackage

// File: rtl/tsa_bit_cnt.sv
module tsa_bit_cnt
  import tsa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  tsa_cfg_t         cfg_i,
  output tsa_cfg_t         cfg_o,
  output logic [POS_W-1:0] pos_o,
  output logic             in_frame_o,
  output logic             run_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  tsa_cfg_t         cfg_q;
  logic [FSLOT_W-1:0] lim_slots;
  logic [CNT_W-1:0]   lim_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      cfg_q <= '0;
    end else if (fsync_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      cfg_q <= cfg_i;
    end else if (run_q && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;  // saturate past frame end
    end
  end

  always_comb begin
    lim_slots = (cfg_q.frame_slots > FSLOT_W'(MAX_SLOTS)) ? FSLOT_W'(MAX_SLOTS)
                                                          : cfg_q.frame_slots;
    lim_bits  = CNT_W'({lim_slots, 3'b000});
  end

  assign in_frame_o = run_q && (cnt_q < lim_bits);
  assign pos_o      = cnt_q[POS_W-1:0];
  assign cfg_o      = cfg_q;
  assign run_o      = run_q;

  a_r2_sync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (cnt_q == '0) && run_q);
  a_r10_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_i |=> $stable(cfg_q));
  a_r11_no_reentry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame_o && !fsync_i) |=> !in_frame_o);
endmodule

// File: rtl/tsa_slot_dec.sv
module tsa_slot_dec
  import tsa_pkg::*;
(
  input  logic             in_frame_i,
  input  logic [POS_W-1:0] pos_i,
  input  dir_cfg_t         cfg_i,
  input  logic             dport_en_i,
  output logic             b1_o,
  output logic             b2_o,
  output logic             d_o
);
  logic hit_b1, hit_b2, hit_d;

  always_comb begin
    hit_b1 = in_frame_i && (pos_i[POS_W-1:3] == cfg_i.b1);
    hit_b2 = in_frame_i && (pos_i[POS_W-1:3] == cfg_i.b2);
    hit_d  = in_frame_i && !dport_en_i && (pos_i[POS_W-1:1] == cfg_i.d);
    // fixed priority: B1 > B2 > D
    b1_o = hit_b1;
    b2_o = hit_b2 && !hit_b1;
    d_o  = hit_d && !hit_b1 && !hit_b2;
  end
endmodule

// File: rtl/tsa_rx_cap.sv
module tsa_rx_cap #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         last_i,
  input  logic         din_i,
  output logic [W-1:0] data_o,
  output logic         vld_o
);
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= en_i && last_i;
      if (en_i) sh_q <= sh_nxt;
      if (en_i && last_i) data_o <= sh_nxt;
    end
  end

  a_r6_vld_follows_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(en_i) && $past(last_i));
  a_r6_vld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner
  import tsa_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fsync_i,
  input  logic [FSLOT_W-1:0]  frame_slots_i,
  input  logic                dport_en_i,
  input  logic [B_SLOT_W-1:0] tx_b1_slot_i,
  input  logic [B_SLOT_W-1:0] tx_b2_slot_i,
  input  logic [D_SLOT_W-1:0] tx_d_slot_i,
  input  logic [B_SLOT_W-1:0] rx_b1_slot_i,
  input  logic [B_SLOT_W-1:0] rx_b2_slot_i,
  input  logic [D_SLOT_W-1:0] rx_d_slot_i,
  input  logic [7:0]          b1_tx_data_i,
  input  logic [7:0]          b2_tx_data_i,
  input  logic [1:0]          d_tx_data_i,
  output logic                ser_tx_o,
  output logic                ser_tx_oe_o,
  input  logic                ser_rx_i,
  output logic [7:0]          b1_rx_data_o,
  output logic                b1_rx_vld_o,
  output logic [7:0]          b2_rx_data_o,
  output logic                b2_rx_vld_o,
  output logic [1:0]          d_rx_data_o,
  output logic                d_rx_vld_o,
  output logic                dport_on_o
);
  tsa_cfg_t         cfg_in, cfg_sh;
  logic [POS_W-1:0] pos;
  logic             in_frame, run;
  dir_cfg_t         dcfg [2];
  logic [2:0]       gnt  [2];  // [0]=B1 [1]=B2 [2]=D ; index 0 tx, 1 rx
  logic [2:0]       boff;
  logic             b_last, d_last;

  always_comb begin
    cfg_in.tx.b1       = tx_b1_slot_i;
    cfg_in.tx.b2       = tx_b2_slot_i;
    cfg_in.tx.d        = tx_d_slot_i;
    cfg_in.rx.b1       = rx_b1_slot_i;
    cfg_in.rx.b2       = rx_b2_slot_i;
    cfg_in.rx.d        = rx_d_slot_i;
    cfg_in.frame_slots = frame_slots_i;
    cfg_in.dport_en    = dport_en_i;
  end

  tsa_bit_cnt i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .cfg_i      (cfg_in),
    .cfg_o      (cfg_sh),
    .pos_o      (pos),
    .in_frame_o (in_frame),
    .run_o      (run)
  );

  assign dcfg[0] = cfg_sh.tx;
  assign dcfg[1] = cfg_sh.rx;

  for (genvar g = 0; g < 2; g++) begin : g_dir
    tsa_slot_dec i_dec (
      .in_frame_i (in_frame),
      .pos_i      (pos),
      .cfg_i      (dcfg[g]),
      .dport_en_i (cfg_sh.dport_en),
      .b1_o       (gnt[g][0]),
      .b2_o       (gnt[g][1]),
      .d_o        (gnt[g][2])
    );
  end

  assign boff   = pos[2:0];
  assign b_last = (boff == 3'd7);
  assign d_last = pos[0];

  always_comb begin
    ser_tx_oe_o = |gnt[0];
    ser_tx_o    = 1'b0;
    if (gnt[0][0])      ser_tx_o = b1_tx_data_i[~boff];
    else if (gnt[0][1]) ser_tx_o = b2_tx_data_i[~boff];
    else if (gnt[0][2]) ser_tx_o = pos[0] ? d_tx_data_i[0] : d_tx_data_i[1];
  end

  tsa_rx_cap #(.W(8)) i_cap_b1 (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (gnt[1][0]), .last_i (b_last),
    .din_i (ser_rx_i), .data_o (b1_rx_data_o), .vld_o (b1_rx_vld_o)
  );
  tsa_rx_cap #(.W(8)) i_cap_b2 (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (gnt[1][1]), .last_i (b_last),
    .din_i (ser_rx_i), .data_o (b2_rx_data_o), .vld_o (b2_rx_vld_o)
  );
  tsa_rx_cap #(.W(2)) i_cap_d (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (gnt[1][2]), .last_i (d_last),
    .din_i (ser_rx_i), .data_o (d_rx_data_o), .vld_o (d_rx_vld_o)
  );

  assign dport_on_o = cfg_sh.dport_en;

  a_r4_oe_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_tx_oe_o |-> in_frame);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !ser_tx_oe_o && !dport_on_o);
  a_r9_rx_b_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({b1_rx_vld_o, b2_rx_vld_o}) <= 1);
  a_r8_dport_no_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dport_on_o |=> !d_rx_vld_o);
endmodule

// File: tb/test_tdm_slot_assigner.sv
module test_tdm_slot_assigner;
  logic       clk = 0, rst_n = 0, fsync = 0, dport_en = 0, rx = 0;
  logic [6:0] fslots = 0;
  logic [5:0] tb1 = 0, tb2 = 0, rb1 = 0, rb2 = 0;
  logic [7:0] td = 0, rd = 0, b1d = 0, b2d = 0;
  logic [1:0] dd = 0;
  logic       tx, tx_oe, b1v, b2v, dv, don;
  logic [7:0] b1r, b2r;
  logic [1:0] dr;

  int n_cmp = 0, n_err = 0;
  string phase = "R1";

  always #10 clk = ~clk;  // 50 MHz

  tdm_slot_assigner i_tdm_slot_assigner (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .frame_slots_i(fslots),
    .dport_en_i(dport_en), .tx_b1_slot_i(tb1), .tx_b2_slot_i(tb2),
    .tx_d_slot_i(td), .rx_b1_slot_i(rb1), .rx_b2_slot_i(rb2),
    .rx_d_slot_i(rd), .b1_tx_data_i(b1d), .b2_tx_data_i(b2d),
    .d_tx_data_i(dd), .ser_tx_o(tx), .ser_tx_oe_o(tx_oe), .ser_rx_i(rx),
    .b1_rx_data_o(b1r), .b1_rx_vld_o(b1v), .b2_rx_data_o(b2r),
    .b2_rx_vld_o(b2v), .d_rx_data_o(dr), .d_rx_vld_o(dv), .dport_on_o(don)
  );

  // reference model state
  bit m_run; int m_pos;
  int m_fs, m_tb1, m_tb2, m_td, m_rb1, m_rb2, m_rd; bit m_dp;
  int sh1, sh2, shd;
  bit e1v, e2v, edv; int e1d, e2d, edd;

  function automatic bit [2:0] grant(int b1, int b2, int d);
    int lim = 8 * ((m_fs > 64) ? 64 : m_fs);
    bit inf = m_run && (m_pos < lim);
    bit h1 = inf && (m_pos / 8 == b1);
    bit h2 = inf && (m_pos / 8 == b2);
    bit hd = inf && !m_dp && (m_pos / 2 == d);
    return {hd && !h1 && !h2, h2 && !h1, h1};
  endfunction

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL [%s] %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit [2:0] g;
    e1v = 0; e2v = 0; edv = 0;
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_fs = 0; m_dp = 0;
      m_tb1 = 0; m_tb2 = 0; m_td = 0; m_rb1 = 0; m_rb2 = 0; m_rd = 0;
    end else begin
      g = grant(m_rb1, m_rb2, m_rd);
      if (g[0]) begin sh1 = ((sh1 << 1) | rx) & 255; if (m_pos % 8 == 7) begin e1v = 1; e1d = sh1; end end
      if (g[1]) begin sh2 = ((sh2 << 1) | rx) & 255; if (m_pos % 8 == 7) begin e2v = 1; e2d = sh2; end end
      if (g[2]) begin shd = ((shd << 1) | rx) & 3;   if (m_pos % 2 == 1) begin edv = 1; edd = shd; end end
      if (fsync) begin
        m_run = 1; m_pos = 0; m_fs = fslots; m_dp = dport_en;
        m_tb1 = tb1; m_tb2 = tb2; m_td = td; m_rb1 = rb1; m_rb2 = rb2; m_rd = rd;
      end else if (m_run && m_pos < 1023) m_pos++;
    end
    #5;
    begin
      bit [2:0] gt;
      int et;
      gt = grant(m_tb1, m_tb2, m_td);
      chk("R4 tx_oe", tx_oe, |gt);
      if (gt[0])      et = b1d[7 - m_pos % 8];
      else if (gt[1]) et = b2d[7 - m_pos % 8];
      else if (gt[2]) et = dd[1 - m_pos % 2];
      else            et = -1;
      if (et >= 0) chk("R3 tx data", tx, et);
      chk("R6 b1 vld", b1v, e1v);
      chk("R6 b2 vld", b2v, e2v);
      chk("R6 d vld", dv, edv);
      if (e1v) chk("R6 b1 byte", b1r, e1d);
      if (e2v) chk("R6 b2 byte", b2r, e2d);
      if (edv) chk("R6 d bits", dr, edd);
      chk("R8 dport_on", don, m_dp);
    end
  end

  // pseudo-random receive stream
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rx   <= lfsr[0];
  end

  task automatic frame(int nbits);
    @(negedge clk) fsync = 1;
    @(negedge clk) fsync = 0;
    repeat (nbits) @(negedge clk);
  endtask

  task automatic cfg(int fs, bit dp, int a, int b, int c, int x, int y, int z);
    fslots = 7'(fs); dport_en = dp;
    tb1 = 6'(a); tb2 = 6'(b); td = 8'(c); rb1 = 6'(x); rb2 = 6'(y); rd = 8'(z);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset oe", tx_oe, 0);
    chk("R1 reset dport", don, 0);
    cfg(8, 1, 0, 1, 4, 0, 1, 4);
    rst_n = 1;
    // R1: no frame sync yet, everything must stay quiet
    repeat (40) @(negedge clk);
    chk("R1 idle oe", tx_oe, 0);

    // R2 R3 R5 R7: sweep slot positions, including ones beyond 10 slots
    phase = "R2";
    for (int k = 0; k < 12; k++) begin
      b1d = 8'(8'h5A + 37 * k); b2d = 8'(8'hC3 ^ (k * 11)); dd = 2'(k);
      cfg(10, 0, k, (k + 4) % 12, (k * 3 + 1) % 48,
          (k + 6) % 12, (k + 1) % 12, (k * 7) % 48);
      frame(88);
    end

    phase = "R8";
    for (int k = 0; k < 3; k++) begin
      cfg(8, 1, 2, 5, 2 * k, 3, 6, 2 * k + 1);
      frame(70);
    end

    phase = "R9";
    cfg(8, 0, 3, 3, 13, 3, 3, 13);   // B1 over B2 over D (D inside slot 3)
    frame(70);
    cfg(8, 0, 1, 5, 21, 2, 5, 21);   // B2 over D (D bits 42,43 in slot 5)
    frame(70);

    phase = "R7";
    cfg(64, 0, 63, 0, 255, 0, 63, 254);
    frame(520);
    cfg(100, 0, 63, 40, 200, 62, 10, 127);
    frame(520);
    cfg(0, 0, 0, 1, 0, 0, 1, 1);
    frame(40);

    phase = "R10";
    cfg(8, 0, 1, 2, 12, 2, 4, 3);
    @(negedge clk) fsync = 1;
    @(negedge clk) fsync = 0;
    repeat (20) @(negedge clk);
    cfg(8, 1, 6, 0, 2, 5, 0, 9);     // mid-frame change, acts next frame
    repeat (50) @(negedge clk);
    frame(70);

    phase = "R11";
    cfg(4, 0, 0, 3, 15, 1, 2, 14);
    frame(200);                      // long tail past the frame limit

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL [%s] watchdog: actual timeout expected completion", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule